// File: doc/BRIEF.md
# Timebase Timer with Edge Capture

This peripheral sits on an 8-bit register bus. It combines two functions. The first is a periodic tick generator that runs from the system clock and raises a timebase flag once per period. The period is chosen by a control bit: a short period, 8000 cycles by default, or a long period, 16000 cycles by default. The second is an 8-bit free-running up-counter. When the capture pin changes level in either direction, the counter's value is latched into a read-only capture register.

Each flag clears as a side effect of reading the register it belongs to. A write to a flag bit does nothing. When a flag-setting event and its clearing read fall on the same cycle, the event wins, so no event is lost. While a captured value is still unread, later pin edges are ignored.

A single interrupt line is raised while the capture flag is set, or while the timebase flag is set and its enable bit is 1. The bus uses plain strobes and has no back-pressure: a write takes effect at the clock edge where it is strobed. A read strobe loads the read data register at its edge. That register then holds until the next read.

Top module: `tbt_timer`

## Requirements
- R1: After reset, every control and flag bit, the capture register, the read data and the interrupt are 0.
- R2: The timebase flag (control/status bit 3) is set once every PERIOD_SHORT cycles while the period select (bit 5) is 0, and once every PERIOD_LONG cycles while it is 1.
- R3: A write that changes the period select restarts the timebase count, so the next flag is set exactly one new period after the edge that applied the write.
- R4: Reading the control/status register (address 0) clears the timebase flag. A write to bit 3 never changes the flag. A tick on the same cycle as that read leaves the flag set.
- R5: The timebase enable (bit 4) gates only the interrupt: with the enable at 0 the timebase flag still sets on schedule.
- R6: The capture pin passes through a two-flop synchroniser. For a level change first sampled at clock edge E, the capture register receives the free counter value (clock edges since reset, modulo 256) as it stood after edge E+1. The capture flag (bit 6) sets at edge E+2. Rising and falling edges are treated alike.
- R7: While the capture flag is set, pin edges neither change the capture register nor leave a pending capture behind.
- R8: The capture flag clears only when the capture register (address 1) is read. Reads and writes of the control/status register do not touch it. A capture on the same cycle as that read leaves the flag set.
- R9: The interrupt is 1 exactly when the capture flag is set, or when both the timebase flag and its enable are 1.
- R10: Bits 7 and 2:0 of the control/status register read as 0. Addresses 2 and 3 read as 0. Writes to address 1 have no effect.
- R11: Read data appears one cycle after the read strobe and shows the contents from before that read's side effects. It then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timebase source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control/status, 1 capture |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the timer with PERIOD_SHORT=10 and PERIOD_LONG=20. With these values many whole periods of both lengths, restarts in the middle of a count, and reads placed on the exact tick cycle all fit in a short run. The counter width stays at 8 bits. Pin edges are spaced seven cycles apart, and seven is odd, so the sweep of 256 captures lands on every counter value once, wrap-around included. Each captured value is predicted from a bench-side count of clock edges since reset.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CSR = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CAP = 2'd1;

  // control/status bit positions
  localparam int BIT_CAPF = 6;
  localparam int BIT_SEL  = 5;
  localparam int BIT_EN   = 4;
  localparam int BIT_TBF  = 3;

  typedef struct packed {
    logic sel;
    logic en;
  } tbt_ctrl_t;
endpackage

// File: rtl/tbt_sync.sv
module tbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int PERIOD_SHORT = 8000,
  parameter int PERIOD_LONG  = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic restart,
  output logic tick
);
  localparam int MAXP = (PERIOD_SHORT > PERIOD_LONG) ? PERIOD_SHORT : PERIOD_LONG;
  localparam int TB_W = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam logic [TB_W-1:0] SHORT_M1 = TB_W'(PERIOD_SHORT - 1);
  localparam logic [TB_W-1:0] LONG_M1  = TB_W'(PERIOD_LONG - 1);

  logic [TB_W-1:0] tb_cnt;
  logic [TB_W-1:0] last;

  assign last = sel ? LONG_M1 : SHORT_M1;
  assign tick = (tb_cnt == last) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           tb_cnt <= '0;
    else if (restart || (tb_cnt == last)) tb_cnt <= '0;
    else                                  tb_cnt <= tb_cnt + 1'b1;
  end
endmodule

// File: rtl/tbt_capture.sv
module tbt_capture #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             lock,
  output logic             fire,
  output logic [CNT_W-1:0] cap_value
);
  logic             pin_s;
  logic             pin_d;
  logic [CNT_W-1:0] free_cnt;

  tbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin),
    .q_sync  (pin_s)
  );

  // any level change between consecutive synchronised samples
  assign fire = (pin_s ^ pin_d) && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d     <= 1'b0;
      free_cnt  <= '0;
      cap_value <= '0;
    end else begin
      pin_d    <= pin_s;
      free_cnt <= free_cnt + 1'b1;
      if (fire) cap_value <= free_cnt;
    end
  end
endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
  import tbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              tb_tick,
  input  logic              cap_fire,
  input  logic [DATA_W-1:0] cap_value,
  output logic [DATA_W-1:0] rdata,
  output tbt_ctrl_t         ctrl,
  output logic              tbf,
  output logic              capf,
  output logic              tb_restart,
  output logic              irq
);
  logic              csr_wr;
  logic              csr_rd;
  logic              cap_rd;
  logic [DATA_W-1:0] csr_view;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign csr_wr = wr && (addr == ADDR_CSR);
  assign csr_rd = rd && (addr == ADDR_CSR);
  assign cap_rd = rd && (addr == ADDR_CAP);
  assign tb_restart = csr_wr && (wdata[BIT_SEL] != ctrl.sel);

  always_comb begin
    csr_view           = '0;
    csr_view[BIT_CAPF] = capf;
    csr_view[BIT_SEL]  = ctrl.sel;
    csr_view[BIT_EN]   = ctrl.en;
    csr_view[BIT_TBF]  = tbf;
  end

  always_comb begin
    case (addr)
      ADDR_CSR: rd_mux = csr_view;
      ADDR_CAP: rd_mux = cap_value;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      tbf   <= 1'b0;
      capf  <= 1'b0;
      rdata <= '0;
    end else begin
      if (csr_wr) begin
        ctrl.sel <= wdata[BIT_SEL];
        ctrl.en  <= wdata[BIT_EN];
      end
      // a set in the same cycle as the clearing read takes priority
      if (tb_tick)     tbf <= 1'b1;
      else if (csr_rd) tbf <= 1'b0;
      if (cap_fire)    capf <= 1'b1;
      else if (cap_rd) capf <= 1'b0;
      if (rd) rdata <= rd_mux;
    end
  end

  assign irq = capf || (tbf && ctrl.en);
endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
  import tbt_pkg::*;
#(
  parameter int PERIOD_SHORT = 8000,
  parameter int PERIOD_LONG  = 16000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_pin,
  output logic              irq
);
  tbt_ctrl_t         ctrl;
  logic              tbf;
  logic              capf;
  logic              tb_tick;
  logic              tb_restart;
  logic              cap_fire;
  logic [DATA_W-1:0] cap_value;

  tbt_timebase #(
    .PERIOD_SHORT (PERIOD_SHORT),
    .PERIOD_LONG  (PERIOD_LONG)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (ctrl.sel),
    .restart (tb_restart),
    .tick    (tb_tick)
  );

  tbt_capture #(
    .CNT_W       (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (cap_pin),
    .lock      (capf),
    .fire      (cap_fire),
    .cap_value (cap_value)
  );

  tbt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .wdata      (bus_wdata),
    .rd         (bus_rd),
    .tb_tick    (tb_tick),
    .cap_fire   (cap_fire),
    .cap_value  (cap_value),
    .rdata      (bus_rdata),
    .ctrl       (ctrl),
    .tbf        (tbf),
    .capf       (capf),
    .tb_restart (tb_restart),
    .irq        (irq)
  );
endmodule

// File: rtl/tbt_timer_chk.sv
module tbt_timer_chk
  import tbt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tbf,
  input logic              capf,
  input logic              en,
  input logic [DATA_W-1:0] cap_value
);
  // R7
  cap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capf |=> $stable(cap_value));

  // R8
  capf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capf && !(bus_rd && bus_addr == ADDR_CAP)) |=> capf);

  // R4
  tbf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbf && !(bus_rd && bus_addr == ADDR_CSR)) |=> tbf);

  // R9
  irq_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capf |-> irq);

  // R9
  irq_tb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbf && en) |-> irq);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capf && !tbf) |-> !irq);

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_CSR) |=> (bus_rdata[7] == 1'b0 && bus_rdata[2:0] == 3'b000));
endmodule

bind tbt_timer tbt_timer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .tbf       (tbf),
  .capf      (capf),
  .en        (ctrl.en),
  .cap_value (cap_value)
);

// File: tb/test_tbt_timer.sv
module test_tbt_timer;
  import tbt_pkg::*;

  localparam int SHORT = 10;
  localparam int LONG  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int unsigned ec;

  always #5 clk = ~clk;

  // clock edges since reset release: the free counter's expected value
  always @(posedge clk) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  tbt_timer #(.PERIOD_SHORT(SHORT), .PERIOD_LONG(LONG)) i_tbt_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cap_pin   (cap_pin),
    .irq       (irq)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at ec=%0d", req, act, exp, ec);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    bus_addr = a;
    bus_wdata = v;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called at the negedge right after a tick; measures the next interval
  task automatic measure(input string req, input int exp);
    logic [7:0] d;
    int n;
    rd_reg(ADDR_CSR, d);
    chk_eq(req, d[BIT_TBF], 1);
    n = 1;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk_eq(req, n, exp);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] held;
    int n;
    int unsigned base;
    int unsigned v1;
    bit seen;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk_eq("R1 irq in reset", irq, 0);
    chk_eq("R1 rdata in reset", bus_rdata, 0);
    rst_n = 1'b1;
    rd_reg(ADDR_CSR, d);
    chk_eq("R1 csr after reset", d, 0);
    rd_reg(ADDR_CAP, d);
    chk_eq("R1 capture after reset", d, 0);

    // R2 short period
    wr_reg(ADDR_CSR, 8'h10);
    wait_irq(n);
    for (int i = 0; i < 3; i++) measure("R2 short period", SHORT);

    // R3 select change restarts, then long periods
    rd_reg(ADDR_CSR, d);
    wr_reg(ADDR_CSR, 8'h30);
    wait_irq(n);
    chk_eq("R3 restart to long", n, LONG);
    for (int i = 0; i < 2; i++) measure("R2 long period", LONG);
    rd_reg(ADDR_CSR, d);
    wr_reg(ADDR_CSR, 8'h10);
    wait_irq(n);
    chk_eq("R3 restart to short", n, SHORT);

    // R4 writes to the flag are ignored
    rd_reg(ADDR_CSR, d);
    wr_reg(ADDR_CSR, 8'h18);
    rd_reg(ADDR_CSR, d);
    chk_eq("R4 write 1 to clear flag", d[BIT_TBF], 0);
    chk_eq("R4 irq after write 1", irq, 0);
    wait_irq(n);
    chk_eq("R2 period across writes", n, SHORT - 3);
    wr_reg(ADDR_CSR, 8'h10);
    rd_reg(ADDR_CSR, d);
    chk_eq("R4 write 0 to set flag", d[BIT_TBF], 1);
    // R4 set wins over same-cycle read: tick lands SHORT-2 edges from here
    repeat (SHORT - 3) @(negedge clk);
    rd_reg(ADDR_CSR, d);
    chk_eq("R11 pre-read contents", d[BIT_TBF], 0);
    chk_eq("R4 set wins irq", irq, 1);
    rd_reg(ADDR_CSR, d);
    chk_eq("R4 set wins flag", d[BIT_TBF], 1);

    // R5 enable gates only the interrupt
    wr_reg(ADDR_CSR, 8'h00);
    seen = 1'b0;
    repeat (SHORT) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk_eq("R5 irq gated", seen, 0);
    wr_reg(ADDR_CSR, 8'h10);
    chk_eq("R9 irq follows enable", irq, 1);
    wr_reg(ADDR_CSR, 8'h00);
    chk_eq("R9 irq drops with enable", irq, 0);
    rd_reg(ADDR_CSR, d);
    chk_eq("R5 flag sets while disabled", d[BIT_TBF], 1);

    // R10 reserved bits, unmapped addresses, read-only capture
    rd_reg(2'd2, d);
    chk_eq("R10 address 2", d, 0);
    rd_reg(2'd3, d);
    chk_eq("R10 address 3", d, 0);
    wr_reg(ADDR_CAP, 8'hAA);
    rd_reg(ADDR_CAP, d);
    chk_eq("R10 capture not writable", d, 0);
    wr_reg(ADDR_CSR, 8'hFF);
    rd_reg(ADDR_CSR, d);
    chk_eq("R10 reserved read 0", d & 8'hF7, 8'h30);
    wr_reg(ADDR_CSR, 8'h00);

    // R11 read data holds between reads
    rd_reg(ADDR_CSR, held);
    repeat (2 * LONG) @(negedge clk);
    chk_eq("R11 rdata holds", bus_rdata, held);

    // R6 sweep: seven-cycle stride visits every counter value
    for (int i = 0; i < 256; i++) begin
      base = ec;
      cap_pin = ~cap_pin;
      repeat (2) @(negedge clk);
      chk_eq("R6 flag not before E+2", irq, 0);
      @(negedge clk);
      chk_eq("R6 flag at E+2", irq, 1);
      rd_reg(ADDR_CAP, d);
      chk_eq("R6 captured value", d, (base + 2) % 256);
      chk_eq("R8 read clears capture flag", irq, 0);
      repeat (3) @(negedge clk);
    end

    // R7 lockout while unread
    base = ec;
    cap_pin = ~cap_pin;
    repeat (3) @(negedge clk);
    v1 = (base + 2) % 256;
    cap_pin = ~cap_pin;
    repeat (4) @(negedge clk);
    rd_reg(ADDR_CSR, d);
    chk_eq("R8 csr read keeps capture flag", d[BIT_CAPF], 1);
    wr_reg(ADDR_CSR, 8'h00);
    rd_reg(ADDR_CSR, d);
    chk_eq("R8 csr write keeps capture flag", d[BIT_CAPF], 1);
    chk_eq("R9 irq from capture flag", irq, 1);
    rd_reg(ADDR_CAP, d);
    chk_eq("R7 value locked", d, v1);
    seen = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk_eq("R7 no pending capture", seen, 0);

    // R8 capture on the same cycle as the clearing read
    base = ec;
    cap_pin = ~cap_pin;
    repeat (2) @(negedge clk);
    rd_reg(ADDR_CAP, d);
    chk_eq("R11 old capture value", d, v1);
    chk_eq("R8 set wins irq", irq, 1);
    rd_reg(ADDR_CAP, d);
    chk_eq("R8 set wins value", d, (base + 2) % 256);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule